// File: doc/BRIEF.md
# Selective Inclusion Back-Invalidation Controller

This controller sits next to a shared second-level cache that serves several cores, each with its own private first-level cache. For every shared-cache slot it keeps a valid flag, a 3-bit data class and one presence bit per core. When the shared cache evicts a line, the controller decides whether the private copies must be removed. Only coherence-relevant classes are kept inclusive, and for those it sends invalidation requests to exactly the cores whose presence bit is set. Lines of the exempt classes leave the shared cache without disturbing any private cache.

The controller also answers coherence lookups. For each lookup it reports whether the shared cache holds the line. It also reports whether the private caches must be probed, which is the case only when the line has left the shared cache and its class is exempt from inclusion. A lookup to a line whose eviction is still in progress is held back until that eviction has finished.

The eviction engine is a three-state machine:
- ST_IDLE accepts an eviction.
  - An inclusive-class eviction with a non-zero presence set moves to ST_INVAL.
  - Any other eviction clears the valid flag at once and stays in ST_IDLE.
- ST_INVAL keeps requests raised until every targeted core has acknowledged, then moves to ST_RETIRE.
- ST_RETIRE clears the valid flag and the presence bits, then returns to ST_IDLE.

Top module: `sib_ctrl`

## Requirements
- R1: Class codes are 0 executable code, 1 read-only, 2 writable private, 3 writable shared, 4 run-time allocated. Codes 5 to 7 are reserved and are treated as inclusive.
- R2: Evicting an inclusive-class line (code 3 or higher) with a non-zero presence set raises `inv_req` on exactly the cores whose presence bit is set. No other request bit rises during that eviction.
- R3: Evicting a line of class 0, 1 or 2 raises no `inv_req`, and `evict_ready` stays high.
- R4: From the cycle after an invalidating eviction is accepted until it completes, `evict_ready` is low. Each request bit stays high until its core's `inv_ack`. The eviction completes only after all targeted cores have acknowledged.
- R5: When an invalidating eviction completes, the line becomes invalid and its presence bits are cleared. A later eviction of the same slot sends no requests.
- R6: A lookup is answered one cycle after acceptance on `lk_rsp_*`. For a valid line the answer is hit=1 and probe=0.
- R7: A lookup that misses on an inclusive-class line answers hit=0 and probe=0.
- R8: A lookup that misses on an exempt-class line answers hit=0 and probe=1, with an all-ones probe mask.
- R9: A lookup to the slot of an eviction in ST_INVAL or ST_RETIRE is stalled (`lk_ready` low) until the eviction completes. Lookups to other slots are not stalled.
- R10: After reset no requests are raised, `evict_ready` is high and no lookup response is valid.
- R11: Run-time allocated lines (code 4) and reserved codes are back-invalidated like writable shared lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fill_valid | input | 1 | Allocate/refill a slot |
| fill_idx | input | IDX_W | Slot being filled |
| fill_cls | input | 3 | Data class of the filled line |
| fill_mask | input | NCORES | Cores now holding a private copy |
| evict_valid | input | 1 | Eviction request |
| evict_idx | input | IDX_W | Slot being evicted |
| evict_ready | output | 1 | Eviction accepted when high with evict_valid |
| inv_req | output | NCORES | Per-core back-invalidation request |
| inv_ack | input | NCORES | Per-core acknowledge, one-cycle pulse |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | IDX_W | Slot looked up |
| lk_ready | output | 1 | Lookup accepted when high with lk_valid |
| lk_rsp_valid | output | 1 | Lookup answer valid |
| lk_rsp_hit | output | 1 | Line present in the shared cache |
| lk_rsp_probe | output | 1 | Private caches must be probed |
| lk_rsp_mask | output | NCORES | Cores to probe |

## Verification
The bench goes after the class boundary between codes 2 and 3, and after the reserved codes. A design that compares the class wrongly either invalidates private lines or leaves stale inclusive copies. Acknowledges come back at staggered times per core, so a design that retires on the first acknowledge raises `evict_ready` while requests are still open. A same-slot lookup issued during a slow invalidation must come back as a miss; a design without the stall would return a stale hit. Re-evicting a retired slot and looking up exempt slots after eviction expose presence bits that were not cleared and a probe decision that ignores the class.

// File: rtl/sib_pkg.sv
package sib_pkg;

    typedef logic [2:0] dclass_t;

    localparam dclass_t CLS_CODE    = 3'd0;
    localparam dclass_t CLS_RDONLY  = 3'd1;
    localparam dclass_t CLS_WPRIV   = 3'd2;
    localparam dclass_t CLS_WSHARED = 3'd3;
    localparam dclass_t CLS_DYNAMIC = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INVAL  = 2'd1,
        ST_RETIRE = 2'd2
    } evst_t;

    // Codes 3 and up (shared, run-time allocated, reserved) stay inclusive.
    function automatic logic needs_inclusion(dclass_t c);
        return (c >= CLS_WSHARED);
    endfunction

endpackage

// File: rtl/sib_dir.sv
module sib_dir
    import sib_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLINES = 16,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  dclass_t           fill_cls,
    input  logic [NCORES-1:0] fill_mask,
    input  logic              drop_en,
    input  logic [IDX_W-1:0]  drop_idx,
    input  logic              retire_en,
    input  logic [IDX_W-1:0]  retire_idx,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic              rda_valid,
    output dclass_t           rda_cls,
    output logic [NCORES-1:0] rda_pres,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic              rdb_valid,
    output dclass_t           rdb_cls
);

    logic [NLINES-1:0] vld_q;
    dclass_t           cls_q  [NLINES];
    logic [NCORES-1:0] pres_q [NLINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < NLINES; i++) begin
                cls_q[i]  <= CLS_CODE;
                pres_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                if (drop_en && drop_idx == IDX_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end
                if (retire_en && retire_idx == IDX_W'(i)) begin
                    vld_q[i]  <= 1'b0;
                    pres_q[i] <= '0;
                end
                if (fill_en && fill_idx == IDX_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    cls_q[i]  <= fill_cls;
                    pres_q[i] <= fill_mask;
                end
            end
        end
    end

    assign rda_valid = vld_q[rda_idx];
    assign rda_cls   = cls_q[rda_idx];
    assign rda_pres  = pres_q[rda_idx];
    assign rdb_valid = vld_q[rdb_idx];
    assign rdb_cls   = cls_q[rdb_idx];

endmodule

// File: rtl/sib_evict_fsm.sv
module sib_evict_fsm
    import sib_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLINES = 16,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [IDX_W-1:0]  evict_idx,
    input  dclass_t           ent_cls,
    input  logic [NCORES-1:0] ent_pres,
    output logic              evict_ready,
    output logic [NCORES-1:0] inv_req,
    input  logic [NCORES-1:0] inv_ack,
    output logic              busy,
    output logic [IDX_W-1:0]  busy_idx,
    output logic              drop_en,
    output logic [IDX_W-1:0]  drop_idx,
    output logic              retire_en,
    output logic [IDX_W-1:0]  retire_idx
);

    evst_t             state_q, state_d;
    logic [NCORES-1:0] pend_q;
    logic [IDX_W-1:0]  idx_q;
    logic              accept;
    logic              targets;

    assign accept  = evict_valid && (state_q == ST_IDLE);
    assign targets = needs_inclusion(ent_cls) && (ent_pres != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && targets) state_d = ST_INVAL;
            ST_INVAL:  if ((pend_q & ~inv_ack) == '0) state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept && targets) begin
                pend_q <= ent_pres;
                idx_q  <= evict_idx;
            end else if (state_q == ST_INVAL) begin
                pend_q <= pend_q & ~inv_ack;
            end
        end
    end

    always_comb begin
        evict_ready = 1'b0;
        inv_req     = '0;
        busy        = 1'b1;
        drop_en     = 1'b0;
        retire_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                evict_ready = 1'b1;
                busy        = 1'b0;
                drop_en     = accept && !targets;
            end
            ST_INVAL:  inv_req   = pend_q;
            ST_RETIRE: retire_en = 1'b1;
            default:   busy      = 1'b0;
        endcase
    end

    assign busy_idx   = idx_q;
    assign drop_idx   = evict_idx;
    assign retire_idx = idx_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req & ~inv_ack) != '0 |=> ((inv_req & $past(inv_req & ~inv_ack)) == $past(inv_req & ~inv_ack))); // R4
    AST_NO_NEW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INVAL) |=> ((inv_req & ~$past(inv_req)) == '0)); // R2
    AST_EXEMPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !needs_inclusion(ent_cls)) |=> (inv_req == '0 && evict_ready)); // R3

endmodule

// File: rtl/sib_lookup.sv
module sib_lookup
    import sib_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLINES = 16,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic              busy,
    input  logic [IDX_W-1:0]  busy_idx,
    input  logic              ent_valid,
    input  dclass_t           ent_cls,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_probe,
    output logic [NCORES-1:0] rsp_mask
);

    logic take;
    logic need_probe;

    assign lk_ready   = !(busy && busy_idx == lk_idx);
    assign take       = lk_valid && lk_ready;
    assign need_probe = !ent_valid && !needs_inclusion(ent_cls);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_probe <= 1'b0;
            rsp_mask  <= '0;
        end else begin
            rsp_valid <= take;
            if (take) begin
                rsp_hit   <= ent_valid;
                rsp_probe <= need_probe;
                rsp_mask  <= need_probe ? '1 : '0;
            end
        end
    end

endmodule

// File: rtl/sib_ctrl.sv
module sib_ctrl
    import sib_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLINES = 16,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [2:0]        fill_cls,
    input  logic [NCORES-1:0] fill_mask,
    input  logic              evict_valid,
    input  logic [IDX_W-1:0]  evict_idx,
    output logic              evict_ready,
    output logic [NCORES-1:0] inv_req,
    input  logic [NCORES-1:0] inv_ack,
    input  logic              lk_valid,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_ready,
    output logic              lk_rsp_valid,
    output logic              lk_rsp_hit,
    output logic              lk_rsp_probe,
    output logic [NCORES-1:0] lk_rsp_mask
);

    logic              drop_en, retire_en, busy;
    logic [IDX_W-1:0]  drop_idx, retire_idx, busy_idx;
    logic              rda_valid, rdb_valid;
    dclass_t           rda_cls, rdb_cls;
    logic [NCORES-1:0] rda_pres;

    sib_dir #(.NCORES(NCORES), .NLINES(NLINES)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_valid),
        .fill_idx   (fill_idx),
        .fill_cls   (fill_cls),
        .fill_mask  (fill_mask),
        .drop_en    (drop_en),
        .drop_idx   (drop_idx),
        .retire_en  (retire_en),
        .retire_idx (retire_idx),
        .rda_idx    (evict_idx),
        .rda_valid  (rda_valid),
        .rda_cls    (rda_cls),
        .rda_pres   (rda_pres),
        .rdb_idx    (lk_idx),
        .rdb_valid  (rdb_valid),
        .rdb_cls    (rdb_cls)
    );

    sib_evict_fsm #(.NCORES(NCORES), .NLINES(NLINES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .evict_valid (evict_valid),
        .evict_idx   (evict_idx),
        .ent_cls     (rda_cls),
        .ent_pres    (rda_pres),
        .evict_ready (evict_ready),
        .inv_req     (inv_req),
        .inv_ack     (inv_ack),
        .busy        (busy),
        .busy_idx    (busy_idx),
        .drop_en     (drop_en),
        .drop_idx    (drop_idx),
        .retire_en   (retire_en),
        .retire_idx  (retire_idx)
    );

    sib_lookup #(.NCORES(NCORES), .NLINES(NLINES)) u_lk (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_idx    (lk_idx),
        .busy      (busy),
        .busy_idx  (busy_idx),
        .ent_valid (rdb_valid),
        .ent_cls   (rdb_cls),
        .lk_ready  (lk_ready),
        .rsp_valid (lk_rsp_valid),
        .rsp_hit   (lk_rsp_hit),
        .rsp_probe (lk_rsp_probe),
        .rsp_mask  (lk_rsp_mask)
    );

    AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && evict_ready && needs_inclusion(rda_cls) && rda_pres != '0) |=> !evict_ready); // R4
    AST_MISS_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && !rdb_valid && !needs_inclusion(rdb_cls)) |=> (lk_rsp_probe && lk_rsp_mask == '1)); // R8
    AST_HIT_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && rdb_valid) |=> (lk_rsp_hit && !lk_rsp_probe)); // R6

endmodule

// File: tb/test_sib_ctrl.sv
`timescale 1ns/1ps
module test_sib_ctrl;
    localparam int NC = 4;
    localparam int NL = 16;
    localparam int IW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [2:0]    fill_cls = '0;
    logic [NC-1:0] fill_mask = '0;
    logic          evict_valid = 1'b0;
    logic [IW-1:0] evict_idx = '0;
    logic          evict_ready;
    logic [NC-1:0] inv_req;
    logic [NC-1:0] inv_ack = '0;
    logic          lk_valid = 1'b0;
    logic [IW-1:0] lk_idx = '0;
    logic          lk_ready;
    logic          lk_rsp_valid, lk_rsp_hit, lk_rsp_probe;
    logic [NC-1:0] lk_rsp_mask;

    sib_ctrl #(.NCORES(NC), .NLINES(NL)) i_sib_ctrl (.*);

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int ack_delay = 1;
    int acks_given = 0;
    int acks_expected = 0;
    bit done = 0;
    logic [NC+1:0] rsp_q[$];
    logic [NC-1:0] inv_q[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic fill(int idx, int cls, logic [NC-1:0] mask);
        @(negedge clk);
        fill_valid = 1'b1; fill_idx = IW'(idx); fill_cls = 3'(cls); fill_mask = mask;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic evict(int idx, logic [NC-1:0] exp_mask);
        @(negedge clk);
        evict_valid = 1'b1; evict_idx = IW'(idx);
        #1;
        while (!evict_ready) begin
            @(negedge clk); #1;
        end
        if (exp_mask != '0) begin
            inv_q.push_back(exp_mask);
            acks_expected += $countones(exp_mask);
        end
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    task automatic lookup(int idx, bit hit, bit probe, logic [NC-1:0] mask, output int stalls);
        stalls = 0;
        @(negedge clk);
        lk_valid = 1'b1; lk_idx = IW'(idx);
        #1;
        while (!lk_ready) begin
            stalls++;
            @(negedge clk); #1;
        end
        rsp_q.push_back({hit, probe, mask});
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!evict_ready || rsp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Lookup response scoreboard
    always @(negedge clk) begin
        if (rst_n && lk_rsp_valid) begin
            if (rsp_q.size() == 0) begin
                chk("R6 unexpected response", 1, 0);
            end else begin
                logic [NC+1:0] e;
                e = rsp_q.pop_front();
                chk("R6/R7/R8 lookup response", {lk_rsp_hit, lk_rsp_probe, lk_rsp_mask}, e);
            end
        end
    end

    // Invalidation scoreboard and ready monitor
    logic [NC-1:0] prev_req = '0;
    logic          prev_ready = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NC-1:0] rising;
            rising = inv_req & ~prev_req;
            if (rising != '0) begin
                if (prev_req != '0) chk("R2 request rose mid-eviction", rising, 0);
                else if (inv_q.size() == 0) chk("R3/R5 unexpected invalidation", inv_req, 0);
                else chk("R2/R11 invalidation targets", inv_req, inv_q.pop_front());
            end
            if (evict_ready && !prev_ready)
                chk("R4 completion after all acks", acks_given, acks_expected);
            prev_req   = inv_req;
            prev_ready = evict_ready;
        end
    end

    // Per-core acknowledge responder, staggered by core
    int cnt [NC];
    always @(negedge clk) begin
        for (int c = 0; c < NC; c++) begin
            if (inv_ack[c]) begin
                inv_ack[c] = 1'b0;
            end else if (inv_req[c]) begin
                if (cnt[c] >= ack_delay + c) begin
                    inv_ack[c] = 1'b1;
                    acks_given++;
                    cnt[c] = 0;
                end else begin
                    cnt[c]++;
                end
            end else begin
                cnt[c] = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        int s1, s2;
        for (int c = 0; c < NC; c++) cnt[c] = 0;
        repeat (3) @(negedge clk);
        chk("R10 reset ready", evict_ready, 1);
        chk("R10 reset requests", inv_req, 0);
        chk("R10 reset response", lk_rsp_valid, 0);
        rst_n = 1'b1;

        fill(1, 3, 4'b0101);  // writable shared
        fill(2, 0, 4'b0011);  // code
        fill(3, 1, 4'b1000);  // read-only
        fill(4, 2, 4'b0110);  // writable private
        fill(5, 4, 4'b1111);  // run-time allocated
        fill(6, 6, 4'b0010);  // reserved
        fill(7, 3, 4'b0000);  // shared, no private holder
        fill(8, 3, 4'b1100);  // shared, used for stall case

        lookup(1, 1, 0, '0, s1);  // R6
        lookup(2, 1, 0, '0, s1);  // R6
        wait_idle();

        evict(1, 4'b0101);         // R2 R4
        wait_idle();
        evict(2, '0);              // R3
        chk("R3 ready after exempt eviction", evict_ready, 1);
        evict(3, '0);              // R3
        evict(4, '0);              // R3
        evict(5, 4'b1111);         // R11
        wait_idle();
        evict(6, 4'b0010);         // R1 reserved code inclusive
        wait_idle();
        evict(7, '0);              // R2 empty presence
        wait_idle();

        lookup(1, 0, 0, '0, s1);   // R7 R5
        lookup(2, 0, 1, '1, s1);   // R8
        lookup(3, 0, 1, '1, s1);   // R8
        lookup(4, 0, 1, '1, s1);   // R8
        lookup(5, 0, 0, '0, s1);   // R7 R11
        lookup(6, 0, 0, '0, s1);   // R7 R1
        wait_idle();
        evict(1, '0);              // R5: presence cleared
        wait_idle();

        ack_delay = 6;
        fork
            evict(8, 4'b1100);
            begin
                repeat (2) @(negedge clk);
                chk("R4 ready low during invalidation", evict_ready, 0);
                lookup(2, 0, 1, '1, s1);
                chk("R9 other slot not stalled", s1, 0);
                lookup(8, 0, 0, '0, s2);
                chk("R9 same slot stalled", (s2 > 0) ? 1 : 0, 1);
            end
        join
        wait_idle();
        chk("R2 all invalidations seen", inv_q.size(), 0);
        chk("R6 all responses seen", rsp_q.size(), 0);
        finish_run();
    end
endmodule